// File: doc/BRIEF.md
# Dual Glitch-Free Clock Generator

This block produces two divided clocks from two free-running sources: a crystal (or external) clock of 2 to 16 MHz and an always-present internal oscillator. One output feeds a host microcontroller. The other feeds a smart card. Each output has its own selection field that picks the source and the divide ratio. The card output can also be parked at a steady high or low level.

The block runs entirely in one fast sampling clock domain, `clk_i`. Each source arrives as a one-cycle strobe that marks one of its rising edges. Each output clock is a register that toggles only on strobes of the source it currently follows. A change of source or ratio takes effect only at a phase boundary, so no high or low phase is ever cut short. For each output, a pending flag shows that a requested configuration has not yet taken over.

A power-reduction input forces the microcontroller clock back to its slow default. The card clock starts out parked low.

Top module: `dual_clk_gen`

## Requirements
- R1: During and after reset, both output clocks are low and both pending flags are low. The card clock is parked low. The microcontroller clock runs from the internal source divided by 8, so its first rise comes 4 oscillator strobes after reset is released.
- R2: The microcontroller field `mcu_sel_i` is decoded as follows: 0 gives internal/8, 1 gives crystal/2, 2 gives crystal/4 and 3 gives internal/2. Each high and each low phase lasts exactly divisor/2 strobes of the selected source.
- R3: The card field `card_sel_i` is decoded as follows: 0 gives crystal/2, 1 gives crystal/4, 2 gives crystal/8 and 3 gives internal/2. Each phase lasts divisor/2 strobes of the selected source.
- R4: While `low_power_i` is high, the microcontroller clock is driven as if `mcu_sel_i` were 0, whatever that field holds.
- R5: A change between two running settings is adopted only on the source strobe that ends a low phase. At that strobe the output stays low and starts a fresh low phase of the new setting. No phase is ever shorter than the setting it belongs to.
- R6: Card code 5 parks the clock high. The output rises on the strobe that ends the current low phase and then stays high.
- R7: Card code 4 parks the clock low. The output falls on the strobe that ends the current high phase and then stays low.
- R8: When a parked card clock is given a running code, the change is adopted on the next strobe of the new source. At that strobe the output is driven low, and the output then rises after divisor/2 further strobes.
- R9: Card codes 6 and 7 behave exactly like code 4.
- R10: A pending flag rises one clock after its selection input differs from the active setting. It clears in the cycle in which the new setting takes over the output.
- R11: A change between the two parked levels needs no strobe. The output takes the new level on the second `clk_i` edge after the field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_i | input | 1 | Synchronous active-high reset |
| xtal_tick_i | input | 1 | One-cycle strobe per crystal clock edge |
| osc_tick_i | input | 1 | One-cycle strobe per internal oscillator edge |
| low_power_i | input | 1 | Forces the microcontroller clock to its slow default |
| mcu_sel_i | input | 2 | Microcontroller clock selection |
| card_sel_i | input | 3 | Card clock selection |
| mcu_clk_o | output | 1 | Divided microcontroller clock |
| card_clk_o | output | 1 | Divided or parked card clock |
| mcu_pending_o | output | 1 | Microcontroller selection not yet in effect |
| card_pending_o | output | 1 | Card selection not yet in effect |

## Verification
The sources are driven with several strobe spacings: strobes on every cycle, strobes with a crystal period shorter than the oscillator period, and strobes with a crystal period longer than it. These spacings tell a ratio counted in strobes apart from one counted in sampling cycles. They also tell apart an adoption at a low-phase boundary from an adoption at any strobe. Selection changes are made both while the clock is running and while it is parked. Codes are also changed in the middle of a phase. Together these separate the rule for running-to-running switches, the rules for parking high and parking low, the rule for starting from a parked level, and the rule for a direct change between parked levels. Rise counts over fixed windows confirm each divide ratio independently of the cycle-by-cycle model.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  // Source encoding shared by decoders and channels
  localparam logic SRC_XTAL = 1'b0;
  localparam logic SRC_OSC  = 1'b1;

  // Card selection codes (decoded in clkgen_req_decode)
  localparam logic [2:0] CARD_X_A    = 3'd0;
  localparam logic [2:0] CARD_X_B    = 3'd1;
  localparam logic [2:0] CARD_X_C    = 3'd2;
  localparam logic [2:0] CARD_O_FAST = 3'd3;
  localparam logic [2:0] CARD_PARK_L = 3'd4;
  localparam logic [2:0] CARD_PARK_H = 3'd5;

  // Microcontroller selection codes
  localparam logic [1:0] MCU_O_SLOW = 2'd0;
  localparam logic [1:0] MCU_X_A    = 2'd1;
  localparam logic [1:0] MCU_X_B    = 2'd2;
  localparam logic [1:0] MCU_O_FAST = 2'd3;
endpackage

// File: rtl/clkgen_req_decode.sv
module clkgen_req_decode
  import clkgen_pkg::*;
#(
  parameter bit IS_CARD    = 1'b1,
  parameter int SEL_W      = 3,
  parameter int CW         = 3,
  parameter int X_DIV_A    = 2,
  parameter int X_DIV_B    = 4,
  parameter int X_DIV_C    = 8,
  parameter int O_DIV_FAST = 2,
  parameter int O_DIV_SLOW = 8,
  parameter bit RST_RUN    = 1'b0,
  parameter bit RST_SRC    = 1'b0,
  parameter int RST_HALF   = 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             req_run_o,
  output logic             req_lvl_o,
  output logic             req_src_o,
  output logic [CW-1:0]    req_half_o
);
  localparam logic [CW-1:0] H_XA = CW'(X_DIV_A / 2);
  localparam logic [CW-1:0] H_XB = CW'(X_DIV_B / 2);
  localparam logic [CW-1:0] H_XC = CW'(X_DIV_C / 2);
  localparam logic [CW-1:0] H_OF = CW'(O_DIV_FAST / 2);
  localparam logic [CW-1:0] H_OS = CW'(O_DIV_SLOW / 2);
  localparam logic [CW-1:0] H_RST = CW'(RST_HALF);

  logic          d_run, d_lvl, d_src;
  logic [CW-1:0] d_half;

  generate
    if (IS_CARD) begin : g_card
      always_comb begin
        d_run  = 1'b1;
        d_lvl  = 1'b0;
        d_src  = SRC_XTAL;
        d_half = H_XA;
        case (sel_i)
          SEL_W'(CARD_X_A):    d_half = H_XA;
          SEL_W'(CARD_X_B):    d_half = H_XB;
          SEL_W'(CARD_X_C):    d_half = H_XC;
          SEL_W'(CARD_O_FAST): begin d_src = SRC_OSC; d_half = H_OF; end
          SEL_W'(CARD_PARK_H): begin d_run = 1'b0; d_lvl = 1'b1; end
          default:             begin d_run = 1'b0; d_lvl = 1'b0; end
        endcase
      end
    end else begin : g_mcu
      always_comb begin
        d_run  = 1'b1;
        d_lvl  = 1'b0;
        d_src  = SRC_OSC;
        d_half = H_OS;
        case (sel_i)
          SEL_W'(MCU_X_A):    begin d_src = SRC_XTAL; d_half = H_XA; end
          SEL_W'(MCU_X_B):    begin d_src = SRC_XTAL; d_half = H_XB; end
          SEL_W'(MCU_O_FAST): d_half = H_OF;
          default:            d_half = H_OS;
        endcase
      end
    end
  endgenerate

  // Request register: cuts the path from the selection pins to the switch logic
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      req_run_o  <= RST_RUN;
      req_lvl_o  <= 1'b0;
      req_src_o  <= RST_SRC;
      req_half_o <= H_RST;
    end else begin
      req_run_o  <= d_run;
      req_lvl_o  <= d_lvl;
      req_src_o  <= d_src;
      req_half_o <= d_half;
    end
  end
endmodule

// File: rtl/clkgen_channel.sv
module clkgen_channel
  import clkgen_pkg::*;
#(
  parameter int CW       = 3,
  parameter bit RST_RUN  = 1'b0,
  parameter bit RST_SRC  = 1'b0,
  parameter int RST_HALF = 1
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          xtick_i,
  input  logic          otick_i,
  input  logic          req_run_i,
  input  logic          req_lvl_i,
  input  logic          req_src_i,
  input  logic [CW-1:0] req_half_i,
  output logic          clk_o,
  output logic          run_o,
  output logic          pending_o
);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] H_RST = CW'(RST_HALF);

  logic          act_run, act_lvl, act_src, clk_q;
  logic [CW-1:0] act_half, cnt;
  logic          cur_tick, new_tick, mism, phase_end;

  assign cur_tick  = (act_src == SRC_OSC) ? otick_i : xtick_i;
  assign new_tick  = (req_src_i == SRC_OSC) ? otick_i : xtick_i;
  assign phase_end = cur_tick && (cnt == act_half - ONE);
  assign mism = req_run_i ? (!act_run || req_src_i != act_src || req_half_i != act_half)
                          : (act_run || req_lvl_i != act_lvl);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      act_run  <= RST_RUN;
      act_lvl  <= 1'b0;
      act_src  <= RST_SRC;
      act_half <= H_RST;
      cnt      <= '0;
      clk_q    <= 1'b0;
    end else if (act_run) begin
      if (phase_end) begin
        cnt <= '0;
        if (clk_q) begin
          // end of high phase: fall; park low may be taken here
          clk_q <= 1'b0;
          if (mism && !req_run_i && !req_lvl_i) begin
            act_run <= 1'b0;
            act_lvl <= 1'b0;
          end
        end else if (mism) begin
          // end of low phase: the only point a running setting is replaced
          if (req_run_i) begin
            act_src  <= req_src_i;
            act_half <= req_half_i;
          end else begin
            act_run <= 1'b0;
            act_lvl <= req_lvl_i;
            clk_q   <= req_lvl_i;
          end
        end else begin
          clk_q <= 1'b1;
        end
      end else if (cur_tick) begin
        cnt <= cnt + ONE;
      end
    end else if (mism) begin
      if (req_run_i) begin
        if (new_tick) begin
          act_run  <= 1'b1;
          act_lvl  <= 1'b0;
          act_src  <= req_src_i;
          act_half <= req_half_i;
          cnt      <= '0;
          clk_q    <= 1'b0;
        end
      end else begin
        act_lvl <= req_lvl_i;
        clk_q   <= req_lvl_i;
      end
    end
  end

  assign clk_o     = clk_q;
  assign run_o     = act_run;
  assign pending_o = mism;
endmodule

// File: rtl/dual_clk_gen.sv
module dual_clk_gen
  import clkgen_pkg::*;
#(
  parameter int X_DIV_A    = 2,
  parameter int X_DIV_B    = 4,
  parameter int X_DIV_C    = 8,
  parameter int O_DIV_FAST = 2,
  parameter int O_DIV_SLOW = 8
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       xtal_tick_i,
  input  logic       osc_tick_i,
  input  logic       low_power_i,
  input  logic [1:0] mcu_sel_i,
  input  logic [2:0] card_sel_i,
  output logic       mcu_clk_o,
  output logic       card_clk_o,
  output logic       mcu_pending_o,
  output logic       card_pending_o
);
  localparam int MAX_X    = (X_DIV_C > X_DIV_B) ? X_DIV_C : X_DIV_B;
  localparam int MAX_O    = (O_DIV_SLOW > O_DIV_FAST) ? O_DIV_SLOW : O_DIV_FAST;
  localparam int MAX_HALF = ((MAX_X > MAX_O) ? MAX_X : MAX_O) / 2;
  localparam int CW       = $clog2(MAX_HALF + 1);

  logic [1:0]    mcu_code;
  logic          m_run, m_lvl, m_src, c_run, c_lvl, c_src;
  logic [CW-1:0] m_half, c_half;
  logic          mcu_run, card_run;

  // Power reduction overrides the host field with the slow default
  assign mcu_code = low_power_i ? MCU_O_SLOW : mcu_sel_i;

  clkgen_req_decode #(
    .IS_CARD(1'b0), .SEL_W(2), .CW(CW),
    .X_DIV_A(X_DIV_A), .X_DIV_B(X_DIV_B), .X_DIV_C(X_DIV_C),
    .O_DIV_FAST(O_DIV_FAST), .O_DIV_SLOW(O_DIV_SLOW),
    .RST_RUN(1'b1), .RST_SRC(SRC_OSC), .RST_HALF(O_DIV_SLOW / 2)
  ) mcu_dec_i (
    .clk_i(clk_i), .rst_i(rst_i), .sel_i(mcu_code),
    .req_run_o(m_run), .req_lvl_o(m_lvl), .req_src_o(m_src), .req_half_o(m_half)
  );

  clkgen_channel #(
    .CW(CW), .RST_RUN(1'b1), .RST_SRC(SRC_OSC), .RST_HALF(O_DIV_SLOW / 2)
  ) mcu_ch_i (
    .clk_i(clk_i), .rst_i(rst_i), .xtick_i(xtal_tick_i), .otick_i(osc_tick_i),
    .req_run_i(m_run), .req_lvl_i(m_lvl), .req_src_i(m_src), .req_half_i(m_half),
    .clk_o(mcu_clk_o), .run_o(mcu_run), .pending_o(mcu_pending_o)
  );

  clkgen_req_decode #(
    .IS_CARD(1'b1), .SEL_W(3), .CW(CW),
    .X_DIV_A(X_DIV_A), .X_DIV_B(X_DIV_B), .X_DIV_C(X_DIV_C),
    .O_DIV_FAST(O_DIV_FAST), .O_DIV_SLOW(O_DIV_SLOW),
    .RST_RUN(1'b0), .RST_SRC(SRC_XTAL), .RST_HALF(X_DIV_A / 2)
  ) card_dec_i (
    .clk_i(clk_i), .rst_i(rst_i), .sel_i(card_sel_i),
    .req_run_o(c_run), .req_lvl_o(c_lvl), .req_src_o(c_src), .req_half_o(c_half)
  );

  clkgen_channel #(
    .CW(CW), .RST_RUN(1'b0), .RST_SRC(SRC_XTAL), .RST_HALF(X_DIV_A / 2)
  ) card_ch_i (
    .clk_i(clk_i), .rst_i(rst_i), .xtick_i(xtal_tick_i), .otick_i(osc_tick_i),
    .req_run_i(c_run), .req_lvl_i(c_lvl), .req_src_i(c_src), .req_half_i(c_half),
    .clk_o(card_clk_o), .run_o(card_run), .pending_o(card_pending_o)
  );
endmodule

// File: rtl/dual_clk_gen_chk.sv
module dual_clk_gen_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       xtal_tick_i,
  input logic       osc_tick_i,
  input logic       low_power_i,
  input logic [1:0] mcu_sel_i,
  input logic [2:0] card_sel_i,
  input logic       mcu_clk_o,
  input logic       card_clk_o,
  input logic       mcu_pending_o,
  input logic       card_pending_o,
  input logic       card_run
);
  // R1: outputs leave reset low
  p_reset_low_r1: assert property (@(posedge clk_i)
    $fell(rst_i) |-> (!card_clk_o && !mcu_clk_o && !card_pending_o && !mcu_pending_o));

  // R5: a running output only moves on a source strobe
  p_card_edge_on_strobe_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (card_run && !xtal_tick_i && !osc_tick_i) |=> $stable(card_clk_o));

  // R2: the host clock never moves without a strobe
  p_mcu_edge_on_strobe_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!xtal_tick_i && !osc_tick_i) |=> $stable(mcu_clk_o));

  // R6: a parked-high card clock stays high while code 5 is held
  p_park_high_holds_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!card_run && card_clk_o && card_sel_i == 3'd5 && $past(card_sel_i) == 3'd5)
    |=> card_clk_o);

  // R10: a settled channel stays settled while its selection is unchanged
  p_card_pending_quiet_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!card_pending_o && $stable(card_sel_i)) |=> !card_pending_o);

  p_mcu_pending_quiet_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!mcu_pending_o && $stable(mcu_sel_i) && $stable(low_power_i)) |=> !mcu_pending_o);
endmodule

bind dual_clk_gen dual_clk_gen_chk chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .xtal_tick_i(xtal_tick_i), .osc_tick_i(osc_tick_i),
  .low_power_i(low_power_i), .mcu_sel_i(mcu_sel_i), .card_sel_i(card_sel_i),
  .mcu_clk_o(mcu_clk_o), .card_clk_o(card_clk_o), .mcu_pending_o(mcu_pending_o),
  .card_pending_o(card_pending_o), .card_run(card_run)
);

// File: tb/dual_clk_gen_tb_top.sv
`timescale 1ns/1ps
module dual_clk_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xt = 1'b0, ot = 1'b0, lp = 1'b0;
  logic [1:0] msel = 2'd0;
  logic [2:0] csel = 3'd4;
  logic mclk, cclk, mpend, cpend;

  always #5 clk = ~clk;

  dual_clk_gen dut_i (
    .clk_i(clk), .rst_i(rst), .xtal_tick_i(xt), .osc_tick_i(ot), .low_power_i(lp),
    .mcu_sel_i(msel), .card_sel_i(csel), .mcu_clk_o(mclk), .card_clk_o(cclk),
    .mcu_pending_o(mpend), .card_pending_o(cpend)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", rq, what, act, exp, $time);
    end
  endtask

  // ---------------- strobe generators ----------------
  int xper = 3, oper = 5, xc = 0, oc = 0;
  always @(negedge clk) begin
    xc = xc + 1; oc = oc + 1;
    if (xc >= xper) xc = 0;
    if (oc >= oper) oc = 0;
    xt <= (xc == 0);
    ot <= (oc == 0);
  end

  // ---------------- reference model (index 0 host, 1 card) ----------------
  int m_run[2], m_lvl[2], m_src[2], m_half[2], m_left[2], m_clk[2];
  int r_run[2], r_lvl[2], r_src[2], r_half[2];

  function automatic int differs(int c);
    if (r_run[c] != 0) return int'(m_run[c] == 0 || r_src[c] != m_src[c] || r_half[c] != m_half[c]);
    return int'(m_run[c] != 0 || r_lvl[c] != m_lvl[c]);
  endfunction

  task automatic decode(int c, int code, output int run, output int lvl, output int src, output int half);
    run = 1; lvl = 0; src = 0; half = 1;
    if (c == 1) begin
      case (code)
        0: half = 1;
        1: half = 2;
        2: half = 4;
        3: begin src = 1; half = 1; end
        5: begin run = 0; lvl = 1; end
        default: begin run = 0; lvl = 0; end
      endcase
    end else begin
      case (code)
        1: half = 1;
        2: half = 2;
        3: begin src = 1; half = 1; end
        default: begin src = 1; half = 4; end
      endcase
    end
  endtask

  task automatic step(int c, int xs, int os);
    int mis, tk;
    mis = differs(c);
    if (m_run[c] != 0) begin
      tk = (m_src[c] != 0) ? os : xs;
      if (tk != 0) begin
        m_left[c] = m_left[c] - 1;
        if (m_left[c] == 0) begin
          m_left[c] = m_half[c];
          if (m_clk[c] != 0) begin
            m_clk[c] = 0;
            if (mis != 0 && r_run[c] == 0 && r_lvl[c] == 0) begin m_run[c] = 0; m_lvl[c] = 0; end
          end else if (mis != 0) begin
            if (r_run[c] != 0) begin
              m_src[c] = r_src[c]; m_half[c] = r_half[c]; m_left[c] = r_half[c];
            end else begin
              m_run[c] = 0; m_lvl[c] = r_lvl[c]; m_clk[c] = r_lvl[c];
            end
          end else m_clk[c] = 1;
        end
      end
    end else if (mis != 0) begin
      if (r_run[c] != 0) begin
        tk = (r_src[c] != 0) ? os : xs;
        if (tk != 0) begin
          m_run[c] = 1; m_lvl[c] = 0; m_src[c] = r_src[c]; m_half[c] = r_half[c];
          m_left[c] = r_half[c]; m_clk[c] = 0;
        end
      end else begin
        m_lvl[c] = r_lvl[c]; m_clk[c] = r_lvl[c];
      end
    end
  endtask

  always @(posedge clk) begin
    int a, b, s, h;
    if (rst) begin
      m_run[0] = 1; m_src[0] = 1; m_half[0] = 4; m_left[0] = 4; m_clk[0] = 0; m_lvl[0] = 0;
      m_run[1] = 0; m_src[1] = 0; m_half[1] = 1; m_left[1] = 1; m_clk[1] = 0; m_lvl[1] = 0;
      r_run[0] = 1; r_src[0] = 1; r_half[0] = 4; r_lvl[0] = 0;
      r_run[1] = 0; r_src[1] = 0; r_half[1] = 1; r_lvl[1] = 0;
    end else begin
      step(0, int'(xt), int'(ot));
      step(1, int'(xt), int'(ot));
      decode(0, lp ? 0 : int'(msel), a, b, s, h);
      r_run[0] = a; r_lvl[0] = b; r_src[0] = s; r_half[0] = h;
      decode(1, int'(csel), a, b, s, h);
      r_run[1] = a; r_lvl[1] = b; r_src[1] = s; r_half[1] = h;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tag, "mcu_clk", int'(mclk), m_clk[0]);
      chk(tag, "card_clk", int'(cclk), m_clk[1]);
      chk(tag, "mcu_pending", int'(mpend), differs(0));
      chk(tag, "card_pending", int'(cpend), differs(1));
    end
  end

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_rises(int which, int n, output int cnt);
    logic prev;
    cnt = 0;
    prev = (which == 0) ? mclk : cclk;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (((which == 0) ? mclk : cclk) && !prev) cnt++;
      prev = (which == 0) ? mclk : cclk;
    end
  endtask

  task automatic near(string rq, string what, int act, int exp);
    checks++;
    if (act < exp - 1 || act > exp + 1) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  initial begin
    int n;
    wait_n(4);
    chk("R1", "card_clk in reset", int'(cclk), 0);
    chk("R1", "mcu_clk in reset", int'(mclk), 0);
    rst = 1'b0;
    wait_n(1);
    chk("R1", "card_pending after reset", int'(cpend), 0);
    chk("R1", "mcu_pending after reset", int'(mpend), 0);
    wait_n(80);

    tag = "R2";
    for (int code = 1; code < 4; code++) begin msel = 2'(code); wait_n(150); end
    msel = 2'd2; wait_n(60);
    count_rises(0, 600, n);
    near("R2", "mcu xtal/4 rises", n, 600 / 12);
    msel = 2'd0; wait_n(120);

    tag = "R3";
    csel = 3'd0; wait_n(60);
    count_rises(1, 600, n);
    near("R3", "card xtal/2 rises", n, 600 / 6);
    csel = 3'd2; wait_n(120);
    count_rises(1, 720, n);
    near("R3", "card xtal/8 rises", n, 720 / 24);
    csel = 3'd3; wait_n(120);
    count_rises(1, 500, n);
    near("R3", "card osc/2 rises", n, 500 / 10);

    tag = "R10";
    csel = 3'd0; wait_n(1);
    chk("R10", "card_pending after code change", int'(cpend), 1);
    wait_n(60);
    chk("R10", "card_pending after take-over", int'(cpend), 0);

    tag = "R5";
    for (int k = 0; k < 12; k++) begin
      csel = 3'(k % 4); wait_n(7 + 3 * k);
    end
    xper = 1; oper = 1;
    for (int k = 0; k < 8; k++) begin csel = 3'((k + 1) % 4); wait_n(5 + k); end
    xper = 7; oper = 2; wait_n(80);

    tag = "R6";
    csel = 3'd1; wait_n(60);
    csel = 3'd5; wait_n(100);
    chk("R6", "card parked high", int'(cclk), 1);
    chk("R6", "card_pending settled", int'(cpend), 0);

    tag = "R11";
    csel = 3'd4; wait_n(2);
    chk("R11", "parked high to low", int'(cclk), 0);
    csel = 3'd5; wait_n(1);
    chk("R11", "level not yet changed", int'(cclk), 0);
    wait_n(1);
    chk("R11", "parked low to high", int'(cclk), 1);

    tag = "R8";
    csel = 3'd2; wait_n(40);
    chk("R8", "card started from high", int'(cpend), 0);
    wait_n(100);

    tag = "R7";
    csel = 3'd4; wait_n(120);
    chk("R7", "card parked low", int'(cclk), 0);
    tag = "R8";
    csel = 3'd3; wait_n(60);

    tag = "R9";
    csel = 3'd6; wait_n(60);
    chk("R9", "code 6 parks low", int'(cclk), 0);
    chk("R9", "code 6 settled", int'(cpend), 0);
    csel = 3'd1; wait_n(60);
    csel = 3'd7; wait_n(80);
    chk("R9", "code 7 parks low", int'(cclk), 0);

    tag = "R4";
    xper = 3; oper = 5;
    msel = 2'd1; wait_n(40);
    lp = 1'b1; wait_n(120);
    chk("R4", "mcu settled under low power", int'(mpend), 0);
    count_rises(0, 800, n);
    near("R4", "mcu osc/8 rises under low power", n, 800 / 40);
    msel = 2'd3; wait_n(1);
    chk("R4", "field change ignored", int'(mpend), 0);
    lp = 1'b0; wait_n(150);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule